// File: doc/BRIEF.md
# Half-duty LCD common timing generator

This block produces the common-side timing for a liquid-crystal panel driver. It divides a slow oscillator input into a square-wave common reference. It then encodes two common-drive lines as three-level digital codes, which an analog output stage turns into the high, mid and low bias voltages. It also tells the segment logic which of two data banks is on show at any moment.

Two mode inputs select the behaviour. In static mode, both common lines carry the reference, using only the high and low levels. In half-duty mode, one common line is selected for one whole reference period, driving high and then low in step with the reference, while the other sits at mid. The roles then swap, with line A first. With external timing selected, the oscillator pin itself is the common reference. Several chained devices keep their frames aligned through a shared open-drain sync line: each device pulls the line low briefly at the start of its frame, and each restarts its frame while it sees the line low.

The oscillator input is asynchronous to the system clock. It is sampled through a synchronizer and counted on its rising edges.

Top module: `lcdc_com_timing`

## Requirements
- R1: After reset with internal timing, the common reference is high, the bank flag is 0 and the sync pull is 0. Common A is high (code 2'b10). Common B is high in static mode and mid (code 2'b01) in half-duty mode.
- R2: With internal timing, the common reference is high for oscillator rising-edge counts 0 to 3 and low for counts 4 to 7, modulo 8. The count runs from reset or from the last sync restart, so the reference runs at one eighth of the oscillator rate.
- R3: In static mode, both common lines carry the same code: high (2'b10) while the reference is high and low (2'b00) while it is low. They never carry mid.
- R4: In half-duty mode with internal timing, common A is selected for counts 0 to 7 and common B for counts 8 to 15, modulo 16. The selected line carries high while the reference is high and low while it is low. The other line carries mid.
- R5: The bank flag is 1 exactly while common B is selected in half-duty mode, and it is always 0 in static mode.
- R6: With external timing, the common reference follows the oscillator input level after the input synchronizer and one register.
- R7: In half-duty mode with external timing, the selected line swaps on each rising edge of the oscillator input, and the first rising edge after reset selects common A. Until that edge, common B is selected.
- R8: In half-duty mode, the sync pull is asserted for exactly one clock cycle at each frame start, which is the step into the first period of common A. It is never asserted in static mode.
- R9: In half-duty mode, while the sync line reads low (sync_in = 0), the frame restarts at the first period of common A and is held there. In static mode, the sync line has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_in | input | 1 | Oscillator input, or the external common signal when ext_timing is 1 |
| half_duty | input | 1 | 1 = half-duty mode, 0 = static mode |
| ext_timing | input | 1 | 1 = osc_in is used directly as the common reference |
| sync_in | input | 1 | Level read from the shared sync line (0 = pulled low) |
| sync_pull | output | 1 | 1 = drive the shared sync line low |
| com_ref | output | 1 | Square-wave common reference |
| com_a | output | 2 | Common A level code (10 high, 01 mid, 00 low) |
| com_b | output | 2 | Common B level code (10 high, 01 mid, 00 low) |
| bank_b | output | 1 | 1 = segment logic shows bank B data |

## Verification
The hardest state to reach from the ports is a frame restart forced by another device in the middle of a frame. No single device ever pulls the line except at the frame start it has already reached. The bench models the wired line as the AND of the device's own release and an extra pull driven by the stimulus. It asserts that extra pull partway through a half-duty frame, sends oscillator edges while the line is held low, then releases the line and checks that counting resumes from the first period of common A. The same extra pull is applied in static mode, where the reference must keep counting.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10
    } lvl_e;

    // Level driven by a common line that is currently selected.
    function automatic lvl_e active_level(input logic ref_level);
        return ref_level ? LVL_HIGH : LVL_LOW;
    endfunction

endpackage

// File: rtl/lcdc_sync.sv
module lcdc_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] rst_val,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = din;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= rst_val;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/lcdc_phase.sv
module lcdc_phase #(
    parameter int REF_DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_lvl,
    input  logic sync_low,
    input  logic half_duty,
    input  logic ext_timing,
    output logic ref_o,
    output logic bank_b_o,
    output logic pull_o
);

    localparam int PW      = REF_DIV_LOG2 + 1;
    localparam int REF_BIT = PW - 2;
    localparam int BANK_BIT = PW - 1;

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          osc_prev;
        logic          ext_bank;
        logic          pull;
    } st_t;

    st_t st_d, st_q;
    logic osc_rise;

    always_comb begin
        st_d          = st_q;
        st_d.pull     = 1'b0;
        st_d.osc_prev = osc_lvl;
        osc_rise      = osc_lvl & ~st_q.osc_prev;

        if (ext_timing) begin
            if (osc_rise) begin
                st_d.ext_bank = ~st_q.ext_bank;
                st_d.pull     = half_duty & st_q.ext_bank;
            end else if (half_duty && sync_low) begin
                st_d.ext_bank = 1'b0;
            end
        end else begin
            if (half_duty && sync_low) begin
                st_d.phase = '0;
            end else if (osc_rise) begin
                st_d.phase = st_q.phase + 1'b1;
                st_d.pull  = half_duty & (&st_q.phase);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= '0;
            st_q.osc_prev <= 1'b0;
            st_q.ext_bank <= 1'b1;
            st_q.pull     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_o    = ext_timing ? st_q.osc_prev : ~st_q.phase[REF_BIT];
    assign bank_b_o = half_duty & (ext_timing ? st_q.ext_bank : st_q.phase[BANK_BIT]);
    assign pull_o   = st_q.pull;

endmodule

// File: rtl/lcdc_drive.sv
module lcdc_drive
    import lcdc_pkg::*;
(
    input  logic half_duty,
    input  logic ref_level,
    input  logic bank_b,
    output lvl_e com_a,
    output lvl_e com_b
);

    lvl_e sel_lvl;

    always_comb begin
        sel_lvl = active_level(ref_level);
        if (!half_duty) begin
            com_a = sel_lvl;
            com_b = sel_lvl;
        end else if (bank_b) begin
            com_a = LVL_MID;
            com_b = sel_lvl;
        end else begin
            com_a = sel_lvl;
            com_b = LVL_MID;
        end
    end

endmodule

// File: rtl/lcdc_com_timing.sv
module lcdc_com_timing #(
    parameter int REF_DIV_LOG2 = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_in,
    input  logic       half_duty,
    input  logic       ext_timing,
    input  logic       sync_in,
    output logic       sync_pull,
    output logic       com_ref,
    output logic [1:0] com_a,
    output logic [1:0] com_b,
    output logic       bank_b
);

    localparam int NSIG = 2;

    logic [NSIG-1:0] raw_in;
    logic [NSIG-1:0] synced;
    logic            ref_lvl;
    logic            bank_sel;
    lcdc_pkg::lvl_e  lvl_a;
    lcdc_pkg::lvl_e  lvl_b;

    assign raw_in = {sync_in, osc_in};

    lcdc_sync #(
        .WIDTH  (NSIG),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (raw_in),
        .rst_val (2'b10),
        .dout    (synced)
    );

    lcdc_phase #(
        .REF_DIV_LOG2 (REF_DIV_LOG2)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_lvl    (synced[0]),
        .sync_low   (~synced[1]),
        .half_duty  (half_duty),
        .ext_timing (ext_timing),
        .ref_o      (ref_lvl),
        .bank_b_o   (bank_sel),
        .pull_o     (sync_pull)
    );

    lcdc_drive u_drive (
        .half_duty (half_duty),
        .ref_level (ref_lvl),
        .bank_b    (bank_sel),
        .com_a     (lvl_a),
        .com_b     (lvl_b)
    );

    assign com_ref = ref_lvl;
    assign com_a   = lvl_a;
    assign com_b   = lvl_b;
    assign bank_b  = bank_sel;

endmodule

// File: rtl/lcdc_com_timing_chk.sv
module lcdc_com_timing_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       half_duty,
    input logic       com_ref,
    input logic [1:0] com_a,
    input logic [1:0] com_b,
    input logic       bank_b,
    input logic       sync_pull
);

    a_r3_static_equal: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duty |-> (com_a == com_b) && (com_a != 2'b01) && (com_a != 2'b11));

    a_r4_one_mid: assert property (@(posedge clk) disable iff (!rst_n)
        half_duty |-> ((com_a == 2'b01) != (com_b == 2'b01)));

    a_r4_selected_follows_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duty && com_a != 2'b01) |-> (com_a == (com_ref ? 2'b10 : 2'b00)));

    a_r5_bank_matches_mid: assert property (@(posedge clk) disable iff (!rst_n)
        half_duty |-> (bank_b == (com_a == 2'b01)));

    a_r5_static_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duty |-> !bank_b);

    a_r8_pull_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pull |=> !sync_pull);

    a_r8_pull_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_pull) |-> (!bank_b && com_ref));

    a_r8_no_pull_static: assert property (@(posedge clk) disable iff (!rst_n)
        !half_duty |-> !sync_pull);

endmodule

bind lcdc_com_timing lcdc_com_timing_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_duty (half_duty),
    .com_ref   (com_ref),
    .com_a     (com_a),
    .com_b     (com_b),
    .bank_b    (bank_b),
    .sync_pull (sync_pull)
);

// File: tb/sim_lcdc_com_timing.sv
module sim_lcdc_com_timing;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] HI = 2'b10;
    localparam logic [1:0] MD = 2'b01;
    localparam logic [1:0] LO = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_in = 1'b0;
    logic       half_duty = 1'b0;
    logic       ext_timing = 1'b0;
    logic       ext_pull = 1'b0;
    logic       sync_in;
    logic       sync_pull;
    logic       com_ref;
    logic [1:0] com_a;
    logic [1:0] com_b;
    logic       bank_b;

    int total = 0;
    int bad = 0;
    int pulls = 0;
    int pull_base = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Wired open-drain line: low if this device or another pulls it.
    assign sync_in = ~(sync_pull | ext_pull);

    lcdc_com_timing u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_in     (osc_in),
        .half_duty  (half_duty),
        .ext_timing (ext_timing),
        .sync_in    (sync_in),
        .sync_pull  (sync_pull),
        .com_ref    (com_ref),
        .com_a      (com_a),
        .com_b      (com_b),
        .bank_b     (bank_b)
    );

    always @(posedge clk) if (rst_n && sync_pull) pulls++;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic hd, input logic ext);
        @(negedge clk);
        rst_n = 1'b0;
        osc_in = 1'b0;
        ext_pull = 1'b0;
        half_duty = hd;
        ext_timing = ext;
        wait_clk(4);
        rst_n = 1'b1;
        pull_base = pulls;
        wait_clk(4);
    endtask

    task automatic osc_pulse();
        @(negedge clk);
        osc_in = 1'b1;
        wait_clk(6);
        osc_in = 1'b0;
        wait_clk(6);
    endtask

    task automatic check_out(input string tag, input logic eref, input logic [1:0] ea,
                             input logic [1:0] eb, input logic ebank);
        total++;
        if (com_ref !== eref || com_a !== ea || com_b !== eb || bank_b !== ebank) begin
            bad++;
            $display("FAIL %s: got ref=%b a=%b b=%b bank=%b, expected ref=%b a=%b b=%b bank=%b",
                     tag, com_ref, com_a, com_b, bank_b, eref, ea, eb, ebank);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
        end
    endtask

    // Expected outputs with internal timing after k oscillator edges.
    task automatic check_count(input string tag, input int k, input logic hd);
        logic       eref;
        logic       ebank;
        logic [1:0] sel;
        eref  = (k % 8) < 4;
        sel   = eref ? HI : LO;
        ebank = hd && ((k % 16) >= 8);
        if (!hd) check_out(tag, eref, sel, sel, 1'b0);
        else if (ebank) check_out(tag, eref, MD, sel, 1'b1);
        else check_out(tag, eref, sel, MD, 1'b0);
    endtask

    task automatic t_static_internal();
        do_reset(1'b0, 1'b0);
        check_out("R1 static reset", 1'b1, HI, HI, 1'b0);
        for (int k = 1; k <= 10; k++) begin
            osc_pulse();
            check_count("R2 R3 static divide", k, 1'b0);
        end
        // R9: a low sync line must not disturb static counting.
        @(negedge clk);
        ext_pull = 1'b1;
        for (int k = 11; k <= 13; k++) begin
            osc_pulse();
            check_count("R9 static ignores sync", k, 1'b0);
        end
        ext_pull = 1'b0;
        wait_clk(4);
        check_int("R8 no pull in static", pulls - pull_base, 0);
    endtask

    task automatic t_half_internal();
        do_reset(1'b1, 1'b0);
        check_out("R1 half reset", 1'b1, HI, MD, 1'b0);
        for (int k = 1; k <= 20; k++) begin
            osc_pulse();
            check_count("R4 R5 half sequence", k, 1'b1);
            if (k == 15) check_int("R8 no pull before frame end", pulls - pull_base, 0);
            if (k == 16) check_int("R8 pull at frame start", pulls - pull_base, 1);
        end
        check_int("R8 single pull per frame", pulls - pull_base, 1);
    endtask

    task automatic t_half_sync_restart();
        do_reset(1'b1, 1'b0);
        for (int k = 1; k <= 5; k++) osc_pulse();
        check_count("R4 before restart", 5, 1'b1);
        @(negedge clk);
        ext_pull = 1'b1;
        wait_clk(6);
        check_count("R9 restart to A", 0, 1'b1);
        osc_pulse();
        check_count("R9 held while low", 0, 1'b1);
        ext_pull = 1'b0;
        wait_clk(4);
        for (int k = 1; k <= 9; k++) osc_pulse();
        check_count("R9 counting resumes", 9, 1'b1);
    endtask

    task automatic t_static_external();
        do_reset(1'b0, 1'b1);
        check_out("R6 ext static low", 1'b0, LO, LO, 1'b0);
        @(negedge clk);
        osc_in = 1'b1;
        wait_clk(6);
        check_out("R6 ext static high", 1'b1, HI, HI, 1'b0);
        osc_in = 1'b0;
        wait_clk(6);
        check_out("R6 ext static back low", 1'b0, LO, LO, 1'b0);
        check_int("R8 no pull ext static", pulls - pull_base, 0);
    endtask

    task automatic t_half_external();
        do_reset(1'b1, 1'b1);
        check_out("R7 ext half before first edge", 1'b0, MD, LO, 1'b1);
        @(negedge clk);
        osc_in = 1'b1;
        wait_clk(6);
        check_out("R7 ext first edge selects A", 1'b1, HI, MD, 1'b0);
        check_int("R8 ext pull at frame start", pulls - pull_base, 1);
        osc_in = 1'b0;
        wait_clk(6);
        check_out("R7 ext A low half", 1'b0, LO, MD, 1'b0);
        osc_in = 1'b1;
        wait_clk(6);
        check_out("R7 ext swap to B", 1'b1, MD, HI, 1'b1);
        osc_in = 1'b0;
        wait_clk(6);
        check_out("R7 ext B low half", 1'b0, MD, LO, 1'b1);
        osc_in = 1'b1;
        wait_clk(6);
        check_out("R7 ext back to A", 1'b1, HI, MD, 1'b0);
        check_int("R8 ext second frame pull", pulls - pull_base, 2);
        osc_in = 1'b0;
        wait_clk(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_static_internal();
        t_half_internal();
        t_half_sync_restart();
        t_static_external();
        t_half_external();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule